// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block serialises 32-bit ARINC 429 words onto a pair of return-to-zero data lines. One line marks one bits and the other marks zero bits. When neither is high the bus is null. The block is clocked by a transmit clock at four times the line bit rate, so every bit occupies four clocks. A host loads the word in one of two ways. In byte mode it loads four successive bytes, and the later three may arrive while the earlier part of the word is already being sent. In word mode it loads all 32 bits at once.

A small control register holds three settings: transmit enable, loopback self test, and a format bit. The format bit is combined with an external format pin to choose byte or word loading, and to choose whether bit 32 carries data or an odd parity bit. An active-low clear-to-send input gates the start of each word, and it may be pulsed to release words one at a time. A three-bit status port reports ready-for-load, idle and underrun. Reading it clears an underrun.

Top module: `a429_word_tx`

## Requirements
- R1: While `mrst` is high and on the first clock after it: `stat` is 3'b011 (stat[0] ready, stat[1] idle, stat[2] underrun), `err` is 0, all four line outputs are low, and the configuration reads enable=1, loop=0, fmt=0. The configuration changes only on a `cfg_wr` clock.
- R2: Each bit lasts four clocks. Its line is high for the first two clocks and both lines are low for the last two. The two lines are never high together, and neither is high while `busy_n` is 1.
- R3: Bits go out word bit 0 first, up to bit 31. In byte mode each load takes `wr_data[7:0]` into the next byte slot (bits 0-7, then 8-15, then 16-23, then 24-31).
- R4: Bit 32 carries data only when `fmt_pin`=0 and fmt=0. In the other three cases it is the odd parity of word bits 0..30. Word mode is selected only by `fmt_pin`=1 with fmt=0.
- R5: In word mode a single load takes all of `wr_data`. `ready` is low from the clock after that load until the word has completed.
- R6: A word starts only when three things hold together: the buffer holds a byte (byte mode) or the full word (word mode), enable is 1, and `cts_n` is 0. Raising `cts_n` after the start does not cut the word short.
- R7: `busy_n` and stat[1] fall when a word starts. For a completed word they stay low for exactly 128 clocks.
- R8: In byte mode `ready` is 1 while fewer than four bytes are held, so the second to fourth bytes can be loaded during transmission. It drops once four bytes are held.
- R9: In byte mode, an underrun occurs when byte k+1 has not been loaded by the end of the last bit of byte k. The word then stops after that bit, `err` and stat[2] become 1, and `ready` goes to 0. Loads and `cts_n` have no effect until the error is cleared.
- R10: A clock with `stat_rd` high clears the underrun, as does `mrst`. The block can then send again.
- R11: In self test, `line_hi` and `line_lo` stay low and the same pulses appear on `loop_hi` and `loop_lo`. Outside self test the loop outputs stay low.
- R12: Between the end of one word and the start of the next, `busy_n` stays high for at least 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit clock, four times the bit rate |
| mrst | input | 1 | Master reset, active high, synchronous |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_en | input | 1 | Control value: transmit enable |
| cfg_loop | input | 1 | Control value: loopback self test |
| cfg_fmt | input | 1 | Control value: format bit |
| fmt_pin | input | 1 | External format select |
| cts_n | input | 1 | Clear to send, active low |
| wr_en | input | 1 | Buffer load strobe |
| wr_data | input | 32 | Load data (bits 7:0 in byte mode) |
| stat_rd | input | 1 | Status read strobe, clears underrun |
| ready | output | 1 | Buffer may accept a load |
| busy_n | output | 1 | Low while a word is on the line |
| err | output | 1 | Underrun flagged |
| stat | output | 3 | {underrun, idle, ready} |
| line_hi | output | 1 | One-bit line |
| line_lo | output | 1 | Zero-bit line |
| loop_hi | output | 1 | One-bit loopback output |
| loop_lo | output | 1 | Zero-bit loopback output |

## Verification
The line outputs are decoded without a register from the sequencer state. The first mark is therefore visible in the cycle right after the clock edge that samples `cts_n` low, and `busy_n` falls on that same edge. `ready` drops on the edge that takes a load. An underrun or a status-read clear shows on the edge after its cause. The bench drives and samples only on falling edges, so every check sits half a cycle after the edge that produced the value. The monitor pops an expected bit whenever a mark begins, and it measures mark widths, busy lengths and gaps in whole falling-edge counts.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic en;
        logic loop;
        logic fmt;
    } tx_cfg_t;

endpackage

// File: rtl/a429_tx_cfg.sv
module a429_tx_cfg
    import a429_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  tx_cfg_t wdata,
    input  logic    fmt_pin,
    output tx_cfg_t cfg,
    output logic    wide,
    output logic    par_en
);

    tx_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) cfg_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{en: 1'b1, loop: 1'b0, fmt: 1'b0};
        else     cfg_q <= cfg_d;
    end

    assign cfg    = cfg_q;
    // word loading only for pin high with the format bit clear
    assign wide   = fmt_pin & ~cfg_q.fmt;
    assign par_en = fmt_pin | cfg_q.fmt;

    // R1: configuration only moves on a write
    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/a429_par_acc.sv
module a429_par_acc (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic bit_in,
    output logic odd_bit
);

    logic acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr)       acc_d = 1'b0;
        else if (step) acc_d = acc_q ^ bit_in;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= acc_d;
    end

    assign odd_bit = ~acc_q;

endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
    import a429_tx_pkg::*;
#(
    parameter int WORD_BITS    = 32,
    parameter int LANE_BITS    = 8,
    parameter int CLKS_PER_BIT = 4,
    parameter int GAP_BITS     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 wide,
    input  logic                 par_en,
    input  logic                 par_bit,
    input  logic                 cts_n,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 stat_rd,
    output logic                 ready,
    output logic                 sending,
    output logic                 mark,
    output logic                 bit_val,
    output logic                 step,
    output logic                 err
);

    localparam int LANES    = WORD_BITS / LANE_BITS;
    localparam int PH_W     = $clog2(CLKS_PER_BIT);
    localparam int BIT_W    = $clog2(WORD_BITS);
    localparam int HAVE_W   = $clog2(LANES + 1);
    localparam int GAP_CLKS = GAP_BITS * CLKS_PER_BIT;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);
    localparam int PH_LAST  = CLKS_PER_BIT - 1;
    localparam int HALF     = CLKS_PER_BIT / 2;

    typedef struct packed {
        tx_state_e              state;
        logic [WORD_BITS-1:0]   word;
        logic [HAVE_W-1:0]      have;
        logic [BIT_W-1:0]       idx;
        logic [PH_W-1:0]        ph;
        logic [GAP_W-1:0]       gap;
        logic                   err;
    } seq_t;

    seq_t s_d, s_q;
    logic ready_c, wr_ok, loaded, lane_end, starved;
    int   lane_no;

    always_comb begin
        s_d     = s_q;
        ready_c = !s_q.err && (wide ? (s_q.have == '0)
                                    : (s_q.have < HAVE_W'(LANES)));
        wr_ok   = wr_en && ready_c;

        if (wr_ok) begin
            if (wide) begin
                s_d.word = wr_data;
                s_d.have = HAVE_W'(LANES);
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (s_q.have == HAVE_W'(k))
                        s_d.word[k*LANE_BITS +: LANE_BITS] = wr_data[LANE_BITS-1:0];
                end
                s_d.have = s_q.have + 1'b1;
            end
        end

        loaded   = wide ? (s_q.have == HAVE_W'(LANES)) : (s_q.have != '0);
        lane_end = (int'(s_q.idx) % LANE_BITS) == LANE_BITS - 1;
        lane_no  = int'(s_q.idx) / LANE_BITS;
        // the next lane must be held (a load on this edge counts)
        starved  = !wide && lane_end && (lane_no < LANES - 1)
                   && (int'(s_d.have) < lane_no + 2);

        if (stat_rd) s_d.err = 1'b0;

        case (s_q.state)
            TX_IDLE: begin
                if (!s_q.err && en && !cts_n && loaded) begin
                    s_d.state = TX_SEND;
                    s_d.idx   = '0;
                    s_d.ph    = '0;
                end
            end
            TX_SEND: begin
                if (s_q.ph == PH_W'(PH_LAST)) begin
                    if (starved) begin
                        s_d.state = TX_IDLE;
                        s_d.err   = 1'b1;
                        s_d.have  = '0;
                    end else if (s_q.idx == BIT_W'(WORD_BITS - 1)) begin
                        s_d.state = TX_GAP;
                        s_d.gap   = '0;
                        s_d.have  = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.ph  = '0;
                    end
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            TX_GAP: begin
                if (s_q.gap == GAP_W'(GAP_CLKS - 1)) s_d.state = TX_IDLE;
                else                                 s_d.gap   = s_q.gap + 1'b1;
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ready   = ready_c;
    assign sending = (s_q.state == TX_SEND);
    assign mark    = sending && (s_q.ph < PH_W'(HALF));
    assign step    = sending && (s_q.ph == PH_W'(PH_LAST));
    assign bit_val = (par_en && s_q.idx == BIT_W'(WORD_BITS - 1)) ? par_bit
                                                                  : s_q.word[s_q.idx];
    assign err     = s_q.err;

    // R2: phase walks one step per clock inside a bit
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == TX_SEND && s_q.ph != PH_W'(PH_LAST))
        |=> (s_q.state == TX_SEND && s_q.ph == $past(s_q.ph) + 1'b1));

    // R6: a word only begins after an enabled, cleared-to-send clock
    assert_start_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == TX_SEND && $past(s_q.state) != TX_SEND)
        |-> $past(en && !cts_n));

    // R9: an underrun halts sending and blocks loads
    assert_err_halts_R9: assert property (@(posedge clk) disable iff (rst)
        s_q.err |-> (s_q.state != TX_SEND && !ready));

    // R5: a full word blocks further loads while it is sent in word mode
    assert_wide_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (wide && s_q.state == TX_SEND) |-> !ready);

    // R12: the null gap never runs straight into a word
    assert_gap_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == TX_GAP) |=> (s_q.state != TX_SEND));

endmodule

// File: rtl/a429_rz_enc.sv
module a429_rz_enc (
    input  logic sending,
    input  logic mark,
    input  logic bit_val,
    input  logic loop,
    output logic line_hi,
    output logic line_lo,
    output logic loop_hi,
    output logic loop_lo
);

    logic hi_c, lo_c;

    always_comb begin
        hi_c    = sending & mark & bit_val;
        lo_c    = sending & mark & ~bit_val;
        line_hi = hi_c & ~loop;
        line_lo = lo_c & ~loop;
        loop_hi = hi_c & loop;
        loop_lo = lo_c & loop;
    end

endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
    import a429_tx_pkg::*;
#(
    parameter int WORD_BITS    = 32,
    parameter int LANE_BITS    = 8,
    parameter int CLKS_PER_BIT = 4,
    parameter int GAP_BITS     = 4
) (
    input  logic                 clk_tx,
    input  logic                 mrst,
    input  logic                 cfg_wr,
    input  logic                 cfg_en,
    input  logic                 cfg_loop,
    input  logic                 cfg_fmt,
    input  logic                 fmt_pin,
    input  logic                 cts_n,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 stat_rd,
    output logic                 ready,
    output logic                 busy_n,
    output logic                 err,
    output logic [2:0]           stat,
    output logic                 line_hi,
    output logic                 line_lo,
    output logic                 loop_hi,
    output logic                 loop_lo
);

    tx_cfg_t cfg_w, cfg_q;
    logic    wide, par_en, par_bit;
    logic    sending, mark, bit_val, step;

    assign cfg_w = '{en: cfg_en, loop: cfg_loop, fmt: cfg_fmt};

    a429_tx_cfg u_cfg (
        .clk     (clk_tx),
        .rst     (mrst),
        .wr      (cfg_wr),
        .wdata   (cfg_w),
        .fmt_pin (fmt_pin),
        .cfg     (cfg_q),
        .wide    (wide),
        .par_en  (par_en)
    );

    a429_tx_seq #(
        .WORD_BITS    (WORD_BITS),
        .LANE_BITS    (LANE_BITS),
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .GAP_BITS     (GAP_BITS)
    ) u_seq (
        .clk     (clk_tx),
        .rst     (mrst),
        .en      (cfg_q.en),
        .wide    (wide),
        .par_en  (par_en),
        .par_bit (par_bit),
        .cts_n   (cts_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stat_rd (stat_rd),
        .ready   (ready),
        .sending (sending),
        .mark    (mark),
        .bit_val (bit_val),
        .step    (step),
        .err     (err)
    );

    a429_par_acc u_par (
        .clk     (clk_tx),
        .rst     (mrst),
        .clr     (!sending),
        .step    (step),
        .bit_in  (bit_val),
        .odd_bit (par_bit)
    );

    a429_rz_enc u_enc (
        .sending (sending),
        .mark    (mark),
        .bit_val (bit_val),
        .loop    (cfg_q.loop),
        .line_hi (line_hi),
        .line_lo (line_lo),
        .loop_hi (loop_hi),
        .loop_lo (loop_lo)
    );

    assign busy_n = !sending;
    assign stat   = {err, busy_n, ready};

    // R11: self test keeps the external lines quiet
    assert_quiet_selftest_R11: assert property (@(posedge clk_tx) disable iff (mrst)
        cfg_q.loop |-> (!line_hi && !line_lo));

    // R2: no mark appears outside a word
    assert_null_idle_R2: assert property (@(posedge clk_tx) disable iff (mrst)
        (line_hi || line_lo || loop_hi || loop_lo) |-> !busy_n);

endmodule

// File: tb/test_a429_word_tx.sv
`timescale 1ns/1ps
module test_a429_word_tx;

    logic        clk = 1'b0;
    logic        mrst, cfg_wr, cfg_en, cfg_loop, cfg_fmt, fmt_pin, cts_n;
    logic        wr_en, stat_rd;
    logic [31:0] wr_data;
    logic        ready, busy_n, err, line_hi, line_lo, loop_hi, loop_lo;
    logic [2:0]  stat;

    always #2 clk = ~clk;

    a429_word_tx i_a429_word_tx (
        .clk_tx (clk), .mrst (mrst), .cfg_wr (cfg_wr), .cfg_en (cfg_en),
        .cfg_loop (cfg_loop), .cfg_fmt (cfg_fmt), .fmt_pin (fmt_pin),
        .cts_n (cts_n), .wr_en (wr_en), .wr_data (wr_data), .stat_rd (stat_rd),
        .ready (ready), .busy_n (busy_n), .err (err), .stat (stat),
        .line_hi (line_hi), .line_lo (line_lo), .loop_hi (loop_hi), .loop_lo (loop_lo)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    exp_bit[$];
    string exp_req[$];
    bit    tb_loop = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard driver side: expected serial bits
    task automatic push_bits(input logic [31:0] w, input int n, input bit par);
        for (int i = 0; i < n; i++) begin
            if (i == 31) begin
                exp_bit.push_back(par ? ~^w[30:0] : w[31]);
                exp_req.push_back("R4");
            end else begin
                exp_bit.push_back(w[i]);
                exp_req.push_back("R3");
            end
        end
    endtask

    // monitor: pops one expected bit per mark, measures widths and runs
    logic  prev_act, hi, lo, act, b;
    string r;
    int    width, low_run, high_run;

    always @(negedge clk) begin
        if (mrst) begin
            prev_act = 1'b0; width = 0; low_run = 0; high_run = 1000;
        end else begin
            hi  = line_hi | loop_hi;
            lo  = line_lo | loop_lo;
            act = hi | lo;
            if (act && !prev_act) begin
                chk(!(hi && lo), "R2", "lines exclusive", 32'({hi, lo}), 32'h1);
                chk(!busy_n, "R2", "mark outside word", 32'(busy_n), 32'h0);
                if (tb_loop)
                    chk(!line_hi && !line_lo, "R11", "external line in self test",
                        32'({line_hi, line_lo}), 32'h0);
                else
                    chk(!loop_hi && !loop_lo, "R11", "loop output outside self test",
                        32'({loop_hi, loop_lo}), 32'h0);
                if (exp_bit.size() == 0) begin
                    chk(1'b0, "R3", "unexpected bit", 32'(hi), 32'h0);
                end else begin
                    b = exp_bit.pop_front();
                    r = exp_req.pop_front();
                    chk(hi == b, r, "serial bit value", 32'(hi), 32'(b));
                end
                width = 1;
            end else if (act) begin
                width++;
            end else if (prev_act) begin
                chk(width == 2, "R2", "mark width", 32'(width), 32'd2);
            end
            prev_act = act;

            if (!busy_n) begin
                if (high_run != 0)
                    chk(high_run >= 16, "R12", "null gap before word", 32'(high_run), 32'd16);
                high_run = 0;
                low_run++;
            end else begin
                if (low_run != 0 && !err)
                    chk(low_run == 128, "R7", "busy_n low length", 32'(low_run), 32'd128);
                low_run = 0;
                high_run++;
            end
        end
    end

    task automatic wr_once(input logic [31:0] d);
        @(negedge clk); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic e, input logic l, input logic f);
        @(negedge clk); cfg_wr = 1'b1; cfg_en = e; cfg_loop = l; cfg_fmt = f;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic send8(input logic [31:0] w, input bit par);
        push_bits(w, 32, par);
        chk(ready, "R8", "ready before first byte", 32'(ready), 32'h1);
        wr_once({24'h0, w[7:0]});
        cts_n = 1'b0;
        while (busy_n) @(negedge clk);
        cts_n = 1'b1;
        for (int k = 1; k < 4; k++) begin
            repeat (12) @(negedge clk);
            chk(ready, "R8", "ready while sending", 32'(ready), 32'h1);
            wr_once({24'h0, w[k*8 +: 8]});
        end
        chk(!ready, "R8", "ready with four bytes held", 32'(ready), 32'h0);
        while (!busy_n) @(negedge clk);
        repeat (24) @(negedge clk);
    endtask

    task automatic send32(input logic [31:0] w);
        push_bits(w, 32, 1'b1);
        chk(ready, "R5", "ready before word load", 32'(ready), 32'h1);
        wr_once(w);
        chk(!ready, "R5", "ready after word load", 32'(ready), 32'h0);
        cts_n = 1'b0;
        while (busy_n) @(negedge clk);
        cts_n = 1'b1;
        chk(!ready, "R5", "ready during word", 32'(ready), 32'h0);
        while (!busy_n) @(negedge clk);
        chk(ready, "R5", "ready after word", 32'(ready), 32'h1);
        repeat (24) @(negedge clk);
    endtask

    task automatic underrun(input logic [31:0] w);
        push_bits(w, 8, 1'b0);
        wr_once({24'h0, w[7:0]});
        cts_n = 1'b0;
        while (busy_n) @(negedge clk);
        cts_n = 1'b1;
        while (!busy_n) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(err, "R9", "err after underrun", 32'(err), 32'h1);
        chk(stat == 3'b110, "R9", "status after underrun", 32'(stat), 32'h6);
        cts_n = 1'b0;
        wr_once(32'h55);
        chk(stat == 3'b110, "R9", "load ignored during error", 32'(stat), 32'h6);
        repeat (60) @(negedge clk);
        chk(busy_n, "R9", "no word during error", 32'(busy_n), 32'h1);
        cts_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        mrst = 1'b1; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_loop = 1'b0; cfg_fmt = 1'b0;
        fmt_pin = 1'b0; cts_n = 1'b1; wr_en = 1'b0; wr_data = '0; stat_rd = 1'b0;
        repeat (4) @(negedge clk);
        chk(stat == 3'b011, "R1", "status in reset", 32'(stat), 32'h3);
        mrst = 1'b0;
        @(negedge clk);
        chk(stat == 3'b011, "R1", "status after reset", 32'(stat), 32'h3);
        chk(!err && busy_n, "R1", "err/busy_n after reset", 32'({err, busy_n}), 32'h1);
        chk(!(line_hi | line_lo | loop_hi | loop_lo), "R1", "lines after reset",
            32'({line_hi, line_lo, loop_hi, loop_lo}), 32'h0);

        // R1/R4 default: byte mode, data in bit 32
        send8(32'hC3A5_1E69, 1'b0);
        // R4: byte mode with parity (pin 0, fmt 1)
        set_cfg(1'b1, 1'b0, 1'b1);
        send8(32'h0F0F_1234, 1'b1);
        // R4/R5: word mode (pin 1, fmt 0)
        fmt_pin = 1'b1;
        set_cfg(1'b1, 1'b0, 1'b0);
        send32(32'hDEAD_BEEF);
        // R12/R6: back-to-back words with cts_n held low
        push_bits(32'h1357_9BDF, 32, 1'b1);
        wr_once(32'h1357_9BDF);
        cts_n = 1'b0;
        while (busy_n) @(negedge clk);
        while (!busy_n) @(negedge clk);
        push_bits(32'h8642_0ACE, 32, 1'b1);
        wr_once(32'h8642_0ACE);
        while (busy_n) @(negedge clk);
        cts_n = 1'b1;
        while (!busy_n) @(negedge clk);
        repeat (24) @(negedge clk);
        // R4: byte mode with parity (pin 1, fmt 1)
        set_cfg(1'b1, 1'b0, 1'b1);
        send8(32'h8000_0001, 1'b1);
        fmt_pin = 1'b0;

        // R6: start gates, with all four bytes preloaded (R8)
        set_cfg(1'b1, 1'b0, 1'b0);
        push_bits(32'h2468_ACE0, 32, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk(ready, "R8", "ready while preloading", 32'(ready), 32'h1);
            wr_once({24'h0, 8'(32'h2468_ACE0 >> (8 * k))});
        end
        repeat (20) @(negedge clk);
        chk(busy_n, "R6", "held by cts_n high", 32'(busy_n), 32'h1);
        set_cfg(1'b0, 1'b0, 1'b0);
        cts_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy_n, "R6", "held by enable low", 32'(busy_n), 32'h1);
        set_cfg(1'b1, 1'b0, 1'b0);
        while (busy_n) @(negedge clk);
        cts_n = 1'b1;
        while (!busy_n) @(negedge clk);
        repeat (24) @(negedge clk);

        // R11: self test loopback
        tb_loop = 1'b1;
        set_cfg(1'b1, 1'b1, 1'b0);
        send8(32'h5A3C_96E1, 1'b0);
        set_cfg(1'b1, 1'b0, 1'b0);
        tb_loop = 1'b0;

        // R9/R10: underrun cleared by status read
        underrun(32'h0000_00B7);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk(!err, "R10", "err cleared by status read", 32'(err), 32'h0);
        chk(stat == 3'b011, "R10", "status after read clear", 32'(stat), 32'h3);
        send8(32'h7E81_42BD, 1'b0);

        // R9/R10/R1: underrun cleared by master reset, which restores config
        set_cfg(1'b1, 1'b0, 1'b1);
        underrun(32'h0000_004C);
        @(negedge clk); mrst = 1'b1;
        repeat (2) @(negedge clk); mrst = 1'b0;
        @(negedge clk);
        chk(!err, "R10", "err cleared by reset", 32'(err), 32'h0);
        chk(stat == 3'b011, "R10", "status after reset clear", 32'(stat), 32'h3);
        send8(32'h8000_0001, 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_bit.size() == 0, "R3", "expected bits left over", 32'(exp_bit.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule